// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that land inside a graphics aperture window into physical addresses. The lookup has two levels. The first level is a 64-slot directory held in on-chip flops. Software fills each slot through one packed 32-bit configuration word. Each present slot names a 4 KB table page in external memory. That page holds 1024 second-level words, and the block reads the one it needs through a memory read port.

A four-entry, fully associative translation cache sits in front of the memory fetch. It is cleared when software drops the enable bit of the control register and then raises it again. A size register sets the aperture to 256, 128, 64 or 32 MB. Requests enter through a valid/ready port. Only one translation is in flight at a time, and each ends in a single-cycle response that carries either a physical address or a fault.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_rd_valid are 0. Every directory slot is absent, so a request anywhere in the window faults without a fetch. The cache is empty, the aperture is 256 MB and the control enable bit is 0.
- R2: A configuration write with cfg_sel = 0 loads a directory slot. Bits 5:0 choose the slot, bit 8 is the present flag and bits 31:12 are the table page number. Bits 11:9 and 7:6 have no effect on translation. A write with bit 8 clear removes the slot. A write with cfg_sel = 3 changes nothing.
- R3: The aperture size is written with cfg_sel = 2 in bits 7:0. Codes 0, 32, 48 and 56 select 64, 32, 16 and 8 directory slots, and any other code is ignored. A request whose directory offset (request bits 31:22 minus aperture_base_hi) is negative or not below the slot count faults without a fetch.
- R4: The directory slot used is the directory offset. A request to an absent slot faults without a fetch, even when a cached translation exists.
- R5: On a cache miss the fetch address is the table page number followed by request bits 21:12 and two zero bits. mem_rd_valid and mem_rd_addr stay constant until mem_rd_ready, and exactly one fetch is issued per miss.
- R6: A fetched word with bit 0 set gives the response address {word[31:12], request[11:0]}. A fetched word with bit 0 clear gives a fault and is not cached. Every fault response carries address 0.
- R7: Successful fetches are cached under the key {slot, request bits 21:12}. A hit responds without a fetch, even if the directory slot was rewritten with a new page. Entries are replaced in round-robin order, and the order restarts at entry 0 after a flush.
- R8: A control write (cfg_sel = 1) whose bit 7 goes from 0 to 1 empties the cache and drops req_ready for exactly the next cycle. Writing bit 7 as 1 when it is already 1, or dropping it to 0, leaves the cache intact.
- R9: A fault or cache hit raises rsp_valid two clock edges after the accepting edge. A miss raises it one edge after the mem_rdata_valid edge. rsp_valid lasts one cycle, and req_ready stays low from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aperture_base_hi | input | 10 | Aperture base address bits 31:22 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 directory, 1 control, 2 size, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | 32 | Physical address, 0 on fault |
| mem_rd_valid | output | 1 | Second-level word read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Address of the second-level word |
| mem_rdata_valid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Second-level word |

## Verification
The response time follows from the registers along each path. A fault or cache hit responds at the second falling edge after the accepting rising edge. A miss takes four falling edges, plus one for each cycle the memory model holds back ready, plus one for each cycle it holds back read data. Every translation task counts falling edges from acceptance until rsp_valid, and compares that count, the response and the number of fetch handshakes against values worked out from the requirements. The flush stall is sampled at the first falling edge after the control write and again one edge later.

// File: rtl/apx_pkg.sv
package apx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xl_state_e;

  localparam logic [1:0] SEL_DIR  = 2'd0;
  localparam logic [1:0] SEL_CTL  = 2'd1;
  localparam logic [1:0] SEL_SIZE = 2'd2;

  localparam logic [7:0] SZ_FULL   = 8'd0;
  localparam logic [7:0] SZ_HALF   = 8'd32;
  localparam logic [7:0] SZ_QUART  = 8'd48;
  localparam logic [7:0] SZ_EIGHTH = 8'd56;

endpackage

// File: rtl/apx_ctl.sv
module apx_ctl
  import apx_pkg::*;
#(
  parameter int SLOTS  = 64,
  parameter int CODE_W = 8,
  localparam int LIM_W = $clog2(SLOTS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_en_bit,
  input  logic              size_we,
  input  logic [CODE_W-1:0] size_code,
  output logic              flush_pend,
  output logic [LIM_W-1:0]  slot_limit
);

  logic             en_q, en_d;
  logic             flush_q, flush_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic [LIM_W-1:0] code_lim;
  logic             code_ok;

  always_comb begin
    code_ok  = 1'b1;
    code_lim = lim_q;
    case (size_code)
      CODE_W'(SZ_FULL):   code_lim = LIM_W'(SLOTS);
      CODE_W'(SZ_HALF):   code_lim = LIM_W'(SLOTS / 2);
      CODE_W'(SZ_QUART):  code_lim = LIM_W'(SLOTS / 4);
      CODE_W'(SZ_EIGHTH): code_lim = LIM_W'(SLOTS / 8);
      default:            code_ok  = 1'b0;
    endcase
  end

  always_comb begin
    en_d    = ctl_we ? ctl_en_bit : en_q;
    flush_d = ctl_we && ctl_en_bit && !en_q;
    lim_d   = (size_we && code_ok) ? code_lim : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      lim_q   <= LIM_W'(SLOTS);
    end else begin
      en_q    <= en_d;
      flush_q <= flush_d;
      lim_q   <= lim_d;
    end
  end

  assign flush_pend = flush_q;
  assign slot_limit = lim_q;

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);  // R8

  AST_LIMIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lim_q) == 1);  // R3

endmodule

// File: rtl/apx_dir.sv
module apx_dir #(
  parameter int SLOTS  = 64,
  parameter int PAGE_W = 20,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_present,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_present,
  output logic [PAGE_W-1:0] rd_page
);

  logic [SLOTS-1:0]  pres_vec;
  logic [PAGE_W-1:0] page_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              sel;
    logic              pres_r;
    logic [PAGE_W-1:0] page_r;

    assign sel = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_r <= 1'b0;
      end else if (sel) begin
        pres_r <= wr_present;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && wr_present) begin
        page_r <= wr_page;
      end
    end

    assign pres_vec[s] = pres_r;
    assign page_arr[s] = page_r;
  end

  assign rd_present = pres_vec[rd_slot];
  assign rd_page    = page_arr[rd_slot];

  AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pres_vec[$past(wr_slot)] == $past(wr_present));  // R2

endmodule

// File: rtl/apx_tcache.sv
module apx_tcache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 16,
  parameter int DATA_W  = 20,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [DATA_W-1:0]  data_arr [ENTRIES];
  logic               fill_go;

  assign fill_go = fill_en && !flush;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;

    always_ff @(posedge clk) begin
      if (fill_go && (ptr_q == PTR_W'(e))) begin
        tag_r  <= fill_tag;
        data_r <= fill_data;
      end
    end

    assign hit_vec[e]  = valid_q[e] && (tag_r == lk_tag);
    assign data_arr[e] = data_r;
  end

  always_comb begin
    lk_data = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e]) lk_data = lk_data | data_arr[e];
    end
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (flush) begin
      valid_d = '0;
      ptr_d   = '0;
    end else if (fill_en) begin
      valid_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));  // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);  // R8

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import apx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int L2_BITS     = 10,
  parameter int DIR_SLOTS   = 64,
  parameter int TC_ENTRIES  = 4,
  parameter int SIZE_CODE_W = 8,
  localparam int DIR_W      = ADDR_W - PAGE_SHIFT - L2_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_W-1:0]  aperture_base_hi,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rdata_valid,
  input  logic [ADDR_W-1:0] mem_rdata
);

  localparam int PPN_W       = ADDR_W - PAGE_SHIFT;
  localparam int SLOT_W      = $clog2(DIR_SLOTS);
  localparam int LIM_W       = SLOT_W + 1;
  localparam int TAG_W       = SLOT_W + L2_BITS;
  localparam int PRESENT_BIT = 8;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // configuration decode
  logic dir_we, ctl_we, size_we;
  logic flush_pend;
  logic [LIM_W-1:0] slot_limit;
  logic unused_bits;

  assign dir_we      = cfg_we && (cfg_sel == SEL_DIR);
  assign ctl_we      = cfg_we && (cfg_sel == SEL_CTL);
  assign size_we     = cfg_we && (cfg_sel == SEL_SIZE);
  assign unused_bits = ^{cfg_wdata[PAGE_SHIFT-1:PRESENT_BIT+1], mem_rdata[PAGE_SHIFT-1:1]};

  apx_ctl #(.SLOTS(DIR_SLOTS), .CODE_W(SIZE_CODE_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_ni),
    .ctl_we     (ctl_we),
    .ctl_en_bit (cfg_wdata[7]),
    .size_we    (size_we),
    .size_code  (cfg_wdata[SIZE_CODE_W-1:0]),
    .flush_pend (flush_pend),
    .slot_limit (slot_limit)
  );

  // request state
  xl_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] fetch_addr_q, fetch_addr_d;
  logic [TAG_W-1:0]  tag_q;
  logic              rsp_fault_q, rsp_fault_d;
  logic [ADDR_W-1:0] rsp_addr_q, rsp_addr_d;
  logic              addr_ld, fetch_ld, rsp_ld;

  // lookup datapath
  logic [DIR_W:0]       dir_off;
  logic                 in_ap;
  logic [SLOT_W-1:0]    slot;
  logic [L2_BITS-1:0]   l2_idx;
  logic [TAG_W-1:0]     lk_tag;
  logic                 dir_present;
  logic [PPN_W-1:0]     dir_page;
  logic                 tc_hit;
  logic [PPN_W-1:0]     tc_data;
  logic                 fill_en;

  assign dir_off = {1'b0, addr_q[ADDR_W-1 -: DIR_W]} - {1'b0, aperture_base_hi};
  assign in_ap   = !dir_off[DIR_W] && (dir_off[DIR_W-1:0] < DIR_W'(slot_limit));
  assign slot    = dir_off[SLOT_W-1:0];
  assign l2_idx  = addr_q[PAGE_SHIFT +: L2_BITS];
  assign lk_tag  = {slot, l2_idx};

  apx_dir #(.SLOTS(DIR_SLOTS), .PAGE_W(PPN_W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_en      (dir_we),
    .wr_slot    (cfg_wdata[SLOT_W-1:0]),
    .wr_present (cfg_wdata[PRESENT_BIT]),
    .wr_page    (cfg_wdata[ADDR_W-1:PAGE_SHIFT]),
    .rd_slot    (slot),
    .rd_present (dir_present),
    .rd_page    (dir_page)
  );

  assign fill_en = (state_q == ST_WAIT) && mem_rdata_valid && mem_rdata[0];

  apx_tcache #(.ENTRIES(TC_ENTRIES), .TAG_W(TAG_W), .DATA_W(PPN_W)) u_tc (
    .clk       (clk),
    .rst_n     (rst_ni),
    .flush     (flush_pend),
    .lk_tag    (lk_tag),
    .lk_hit    (tc_hit),
    .lk_data   (tc_data),
    .fill_en   (fill_en),
    .fill_tag  (tag_q),
    .fill_data (mem_rdata[ADDR_W-1:PAGE_SHIFT])
  );

  // next state
  always_comb begin
    state_d      = state_q;
    addr_ld      = 1'b0;
    fetch_ld     = 1'b0;
    rsp_ld       = 1'b0;
    rsp_fault_d  = rsp_fault_q;
    rsp_addr_d   = rsp_addr_q;
    fetch_addr_d = {dir_page, l2_idx, 2'b00};
    req_ready    = (state_q == ST_IDLE) && !flush_pend;
    case (state_q)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          state_d = ST_CHECK;
          addr_ld = 1'b1;
        end
      end
      ST_CHECK: begin
        if (!in_ap || !dir_present) begin
          state_d     = ST_RESP;
          rsp_ld      = 1'b1;
          rsp_fault_d = 1'b1;
          rsp_addr_d  = '0;
        end else if (tc_hit) begin
          state_d     = ST_RESP;
          rsp_ld      = 1'b1;
          rsp_fault_d = 1'b0;
          rsp_addr_d  = {tc_data, addr_q[PAGE_SHIFT-1:0]};
        end else begin
          state_d  = ST_FETCH;
          fetch_ld = 1'b1;
        end
      end
      ST_FETCH: begin
        if (mem_rd_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rdata_valid) begin
          state_d = ST_RESP;
          rsp_ld  = 1'b1;
          if (mem_rdata[0]) begin
            rsp_fault_d = 1'b0;
            rsp_addr_d  = {mem_rdata[ADDR_W-1:PAGE_SHIFT], addr_q[PAGE_SHIFT-1:0]};
          end else begin
            rsp_fault_d = 1'b1;
            rsp_addr_d  = '0;
          end
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (addr_ld)  addr_q <= req_addr;
    if (fetch_ld) begin
      fetch_addr_q <= fetch_addr_d;
      tag_q        <= lk_tag;
    end
    if (rsp_ld) begin
      rsp_fault_q <= rsp_fault_d;
      rsp_addr_q  <= rsp_addr_d;
    end
  end

  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_fault    = rsp_fault_q;
  assign rsp_addr     = rsp_addr_q;
  assign mem_rd_valid = (state_q == ST_FETCH);
  assign mem_rd_addr  = fetch_addr_q;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid);  // R9

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));  // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_valid |-> !req_ready);  // R5

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid && rsp_fault |-> rsp_addr == '0);  // R6

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_pend |-> !req_ready);  // R8

  AST_OUTSIDE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_CHECK) && !in_ap |=> !mem_rd_valid && rsp_valid && rsp_fault);  // R3

endmodule

// File: tb/aperture_xlate_test.sv
module aperture_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  aperture_base_hi;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_addr;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rdata_valid;
  logic [31:0] mem_rdata;

  int n_cmp  = 0;
  int n_fail = 0;
  int fetch_cnt = 0;
  logic [31:0] last_fetch_addr = '0;
  int mem_dly = 0;
  int mem_lat = 1;

  localparam logic [19:0] P0 = 20'h12345;
  localparam logic [19:0] P1 = 20'h6789A;
  localparam logic [19:0] PR = 20'h0BEEF;

  always #10 clk = ~clk;

  aperture_xlate uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .aperture_base_hi (aperture_base_hi),
    .cfg_we           (cfg_we),
    .cfg_sel          (cfg_sel),
    .cfg_wdata        (cfg_wdata),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_addr         (req_addr),
    .rsp_valid        (rsp_valid),
    .rsp_fault        (rsp_fault),
    .rsp_addr         (rsp_addr),
    .mem_rd_valid     (mem_rd_valid),
    .mem_rd_ready     (mem_rd_ready),
    .mem_rd_addr      (mem_rd_addr),
    .mem_rdata_valid  (mem_rdata_valid),
    .mem_rdata        (mem_rdata)
  );

  // second-level word stored at a memory address; entry index 7 is unmapped
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] pg;
    pg = a[31:12] ^ 20'h5A5A5 ^ {10'b0, a[11:2]};
    return {pg, 11'b0, (a[11:2] != 10'd7)};
  endfunction

  function automatic logic [31:0] ap_addr(input int s, input int l2, input int off);
    return 32'h4000_0000 + (32'(s) << 22) + (32'(l2) << 12) + 32'(off);
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  // memory model
  initial begin
    mem_rd_ready    = 1'b0;
    mem_rdata_valid = 1'b0;
    mem_rdata       = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [31:0] fa;
        repeat (mem_dly) @(negedge clk);
        fa = mem_rd_addr;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready    = 1'b0;
        fetch_cnt++;
        last_fetch_addr = fa;
        repeat (mem_lat) @(negedge clk);
        mem_rdata       = mem_word(fa);
        mem_rdata_valid = 1'b1;
        @(negedge clk);
        mem_rdata_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic dir_set(input int s, input logic [19:0] pg);
    cfg_write(2'd0, {pg, 3'b000, 1'b1, 2'b00, 6'(s)});
  endtask

  // one translation; pg is the table page the result must come from
  task automatic xlate(input string rq, input logic [31:0] a, input logic [19:0] pg,
                       input bit exp_fault, input bit exp_fetch, input int exp_lat);
    int n;
    int f0;
    logic [31:0] ea, w, exp_addr;
    ea = {pg, a[21:12], 2'b00};
    w  = mem_word(ea);
    exp_addr = exp_fault ? 32'h0 : {w[31:12], a[11:0]};
    f0 = fetch_cnt;
    @(negedge clk);
    check(rq, "req_ready", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
    end while (!rsp_valid && n < 80);
    check(rq, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(rq, "rsp_fault", {31'b0, rsp_fault}, {31'b0, exp_fault});
    check(rq, "rsp_addr", rsp_addr, exp_addr);
    check(rq, "fetches", 32'(fetch_cnt - f0), {31'b0, exp_fetch});
    if (exp_fetch) check(rq, "fetch_addr", last_fetch_addr, ea);
    check(rq, "latency", 32'(n), 32'(exp_lat));
    @(negedge clk);
    check(rq, "rsp_pulse", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1", "req_ready", {31'b0, req_ready}, 32'd1);
    check("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1", "mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
    xlate("R1", ap_addr(0, 5, 12'h123), P0, 1, 0, 2);
    xlate("R1", ap_addr(63, 1, 0), P0, 1, 0, 2);
  endtask

  task automatic t_dir_fetch();
    cfg_write(2'd1, 32'h2280);
    // attribute and reserved bits set: no effect (R2)
    cfg_write(2'd0, {P0, 3'b101, 1'b1, 2'b11, 6'd0});
    xlate("R2", ap_addr(0, 5, 12'hABC), P0, 0, 1, 5);
    xlate("R5", ap_addr(0, 9, 12'h004), P0, 0, 1, 5);
    // select 3 is ignored (R2)
    cfg_write(2'd3, {P1, 3'b000, 1'b1, 2'b00, 6'd2});
    xlate("R2", ap_addr(2, 1, 0), P1, 1, 0, 2);
  endtask

  task automatic t_cache_hit();
    xlate("R7", ap_addr(0, 5, 12'h010), P0, 0, 0, 2);
    xlate("R9", ap_addr(0, 9, 12'hFFF), P0, 0, 0, 2);
  endtask

  task automatic t_invalid_l2();
    xlate("R6", ap_addr(0, 7, 12'h040), P0, 1, 1, 5);
    xlate("R6", ap_addr(0, 7, 12'h044), P0, 1, 1, 5);
  endtask

  task automatic t_teardown();
    cfg_write(2'd0, 32'd0);
    xlate("R4", ap_addr(0, 5, 12'h010), P0, 1, 0, 2);
    dir_set(0, P1);
    // stale entry still serves until a flush
    xlate("R7", ap_addr(0, 5, 12'h020), P0, 0, 0, 2);
  endtask

  task automatic t_flush();
    cfg_write(2'd1, 32'h2280);
    check("R8", "no_stall_hold", {31'b0, req_ready}, 32'd1);
    xlate("R8", ap_addr(0, 5, 12'h030), P0, 0, 0, 2);
    cfg_write(2'd1, 32'h2200);
    check("R8", "no_stall_fall", {31'b0, req_ready}, 32'd1);
    xlate("R8", ap_addr(0, 5, 12'h030), P0, 0, 0, 2);
    cfg_write(2'd1, 32'h2280);
    check("R8", "stall", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    check("R8", "stall_end", {31'b0, req_ready}, 32'd1);
    xlate("R8", ap_addr(0, 5, 12'h030), P1, 0, 1, 5);
  endtask

  task automatic t_round_robin();
    dir_set(1, PR);
    cfg_write(2'd1, 32'h2200);
    cfg_write(2'd1, 32'h2280);
    for (int k = 1; k <= 5; k++) xlate("R7", ap_addr(1, k, 0), PR, 0, 1, 5);
    xlate("R7", ap_addr(1, 2, 8), PR, 0, 0, 2);
    mem_dly = 2; mem_lat = 3;
    xlate("R5", ap_addr(1, 1, 8), PR, 0, 1, 9);
    mem_dly = 0; mem_lat = 1;
    xlate("R7", ap_addr(1, 2, 8), PR, 0, 1, 5);
  endtask

  task automatic t_size();
    for (int s = 0; s < 64; s++) begin
      if (s == 7 || s == 15 || s == 16 || s == 31 || s == 40) dir_set(s, 20'h0AB00 + 20'(s));
    end
    cfg_write(2'd1, 32'h2200);
    cfg_write(2'd1, 32'h2280);
    xlate("R3", ap_addr(40, 3, 0), 20'h0AB28, 0, 1, 5);
    cfg_write(2'd2, 32'd56);
    xlate("R3", ap_addr(40, 3, 0), 20'h0AB28, 1, 0, 2);
    xlate("R3", ap_addr(7, 3, 0), 20'h0AB07, 0, 1, 5);
    xlate("R3", 32'h3FC0_3000, 20'h0AB07, 1, 0, 2);
    cfg_write(2'd2, 32'h11);
    xlate("R3", ap_addr(40, 3, 0), 20'h0AB28, 1, 0, 2);
    cfg_write(2'd2, 32'd48);
    xlate("R3", ap_addr(15, 3, 0), 20'h0AB0F, 0, 1, 5);
    xlate("R3", ap_addr(16, 3, 0), 20'h0AB10, 1, 0, 2);
    cfg_write(2'd2, 32'd32);
    xlate("R3", ap_addr(16, 3, 0), 20'h0AB10, 0, 1, 5);
    xlate("R3", ap_addr(31, 3, 0), 20'h0AB1F, 0, 1, 5);
    xlate("R3", ap_addr(40, 3, 0), 20'h0AB28, 1, 0, 2);
    cfg_write(2'd2, 32'd0);
    xlate("R3", ap_addr(40, 3, 0), 20'h0AB28, 0, 1, 5);
  endtask

  initial begin
    rst_n = 1'b0;
    aperture_base_hi = 10'h100;
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir_fetch();
    t_cache_hit();
    t_invalid_l2();
    t_teardown();
    t_flush();
    t_round_robin();
    t_size();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule